// File: doc/BRIEF.md
# Wake-up Event Indicator Generator

This block turns wake-up detections into an external power-management-event indication. Two single-cycle detection inputs, one for a magic-packet match and one for a wake-frame match, are each gated by their own enable. Each accepted detection sets a sticky status flag and raises an internal active state. That state drives a pad as push-pull or open-drain, with a selectable polarity. The active state lasts for a fixed number of clock cycles (pulse mode) or until the host releases it (level mode). The host releases it by writing ones to clear the status flags or by writing the power management register.

The block receives register write strobes and data that are already decoded. A wake register write carries the two enables and the two clear bits. A configuration write carries the drive options. A strobe marks a write to the power management register. The active indication can also be ORed into an interrupt output, which has its own polarity and also carries a system interrupt request.

Top module: `wake_indicator`

## Requirements
- R1: After reset both enables and both flags are 0. The configuration is level mode, active low, push-pull, interrupt routing off and interrupt active low. With `sys_irq_i` low this gives `pme_data_o`=1, `pme_oe_o`=1 and `irq_o`=1.
- R2: A magic detection counts only while wake-write bit 0 (magic enable) is set, and a frame detection counts only while bit 1 (frame enable) is set. A gated-off detection changes neither `wake_flags_o` nor the indicator.
- R3: An accepted detection sets its flag in `wake_flags_o` (bit 0 magic, bit 1 frame) on the next cycle. A wake write with bit 2 clears the magic flag and bit 3 clears the frame flag. A detection in the same cycle as its clear leaves the flag set.
- R4: In level mode (config bit 0 = 0) the indicator becomes active the cycle after an accepted detection and stays active until it is released.
- R5: A release deasserts the indicator on the next cycle. A release is either a power-management write strobe or a wake write whose clears leave both flags at 0. An accepted detection in the same cycle wins over a release.
- R6: In pulse mode (config bit 0 = 1) an accepted detection makes the indicator active for exactly `PULSE_CYCLES` cycles. It then goes inactive by itself and the flags are untouched.
- R7: An accepted detection during a running pulse restarts the full `PULSE_CYCLES` window.
- R8: Config bit 1 selects the pad polarity: 1 means active high, 0 means active low.
- R9: Config bit 2 selects open-drain. In that mode `pme_oe_o` is 1 only while active and `pme_data_o` carries the active level. Push-pull keeps `pme_oe_o` at 1.
- R10: `irq_o` is the OR of `sys_irq_i` and the active indication, with the active indication included only when config bit 3 is set. Config bit 4 set makes `irq_o` active high.
- R11: Enable and configuration writes take effect for the cycle after the write. A detection in the same cycle as the write uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| magic_det_i | input | 1 | Single-cycle magic-packet detection |
| frame_det_i | input | 1 | Single-cycle wake-frame detection |
| wake_wr_i | input | 1 | Wake register write strobe |
| wake_wdata_i | input | 4 | Enables [1:0], clear-by-one bits [3:2] |
| pm_wr_i | input | 1 | Power management register write strobe |
| cfg_wr_i | input | 1 | Indicator configuration write strobe |
| cfg_wdata_i | input | 5 | Pulse mode, polarity, open-drain, irq route, irq polarity |
| sys_irq_i | input | 1 | System interrupt request |
| wake_flags_o | output | 2 | Status flags (bit 0 magic, bit 1 frame) |
| pme_data_o | output | 1 | Indicator pad data |
| pme_oe_o | output | 1 | Indicator pad output enable |
| irq_o | output | 1 | Interrupt pad level |

## Verification
The assertions assume that detection inputs are clean single-cycle pulses sampled on the clock. They also assume that write strobes last one cycle and arrive with their data in the same cycle. The stimulus drives every input half a cycle away from the active edge and holds each strobe for exactly one cycle. It also places detections deliberately in the same cycle as enable writes, clears and power-management writes, so that the priority rules are exercised rather than avoided.

// File: rtl/wake_ind_pkg.sv
package wake_ind_pkg;

  localparam int NUM_EVT = 2;

  typedef struct packed {
    logic irq_high;
    logic irq_route;
    logic open_drain;
    logic active_high;
    logic pulse_mode;
  } ind_cfg_t;

  function automatic logic level_of(input logic active, input logic high);
    return high ? active : ~active;
  endfunction

  function automatic logic all_cleared(input logic [NUM_EVT-1:0] flags);
    return ~|flags;
  endfunction

endpackage

// File: rtl/wake_event_flags.sv
module wake_event_flags
  import wake_ind_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   det_i,
  input  logic                 wake_wr_i,
  input  logic [2*NUM_EVT-1:0] wake_wdata_i,
  output logic                 any_hit_o,
  output logic                 clr_release_o,
  output logic [NUM_EVT-1:0]   flags_o
);

  logic [NUM_EVT-1:0] en_q;
  logic [NUM_EVT-1:0] flag_q;
  logic [NUM_EVT-1:0] flag_d;
  logic [NUM_EVT-1:0] hit;
  logic [NUM_EVT-1:0] clr;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_lane
    assign hit[g]    = det_i[g] & en_q[g];
    assign clr[g]    = wake_wr_i & wake_wdata_i[NUM_EVT+g];
    assign flag_d[g] = hit[g] | (flag_q[g] & ~clr[g]);

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> flag_q[g]);  // R3
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !hit[g]) |=> !flag_q[g]);  // R3
    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[g] && !flag_q[g]) |=> !flag_q[g]);  // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (wake_wr_i) en_q <= wake_wdata_i[NUM_EVT-1:0];
      flag_q <= flag_d;
    end
  end

  assign any_hit_o     = |hit;
  assign clr_release_o = wake_wr_i & (|clr) & all_cleared(flag_d);
  assign flags_o       = flag_q;

endmodule

// File: rtl/wake_active_ctrl.sv
module wake_active_ctrl #(
  parameter int PULSE_CYCLES = 6_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic release_i,
  input  logic pulse_mode_i,
  output logic active_o
);

  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          latch_q;
  logic          pulse_live;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic hit,
                                               input logic rel);
    if (hit)            return LOAD;
    else if (rel)       return '0;
    else if (c != '0)   return c - 1'b1;
    else                return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      cnt_q <= next_count(cnt_q, hit_i, release_i);
      if (hit_i)          latch_q <= 1'b1;
      else if (release_i) latch_q <= 1'b0;
    end
  end

  assign pulse_live = (cnt_q != '0);
  assign active_o   = pulse_mode_i ? pulse_live : latch_q;

  AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> (cnt_q == LOAD));  // R7
  AST_PULSE_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_live && !hit_i && !release_i) |=> (cnt_q == $past(cnt_q) - 1'b1));  // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !hit_i && !release_i) |=> latch_q);  // R4
  AST_RELEASE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !hit_i) |=> (!latch_q && !pulse_live));  // R5

endmodule

// File: rtl/wake_pad_drive.sv
module wake_pad_drive
  import wake_ind_pkg::*;
(
  input  logic     active_i,
  input  ind_cfg_t cfg_i,
  input  logic     sys_irq_i,
  output logic     pme_data_o,
  output logic     pme_oe_o,
  output logic     irq_o
);

  logic irq_req;

  always_comb begin
    if (cfg_i.open_drain) begin
      pme_oe_o   = active_i;
      pme_data_o = cfg_i.active_high;
    end else begin
      pme_oe_o   = 1'b1;
      pme_data_o = level_of(active_i, cfg_i.active_high);
    end
  end

  assign irq_req = sys_irq_i | (cfg_i.irq_route & active_i);
  assign irq_o   = level_of(irq_req, cfg_i.irq_high);

endmodule

// File: rtl/wake_indicator.sv
module wake_indicator
  import wake_ind_pkg::*;
#(
  parameter int PULSE_CYCLES = 6_000_000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         magic_det_i,
  input  logic         frame_det_i,
  input  logic         wake_wr_i,
  input  logic [3:0]   wake_wdata_i,
  input  logic         pm_wr_i,
  input  logic         cfg_wr_i,
  input  logic [4:0]   cfg_wdata_i,
  input  logic         sys_irq_i,
  output logic [1:0]   wake_flags_o,
  output logic         pme_data_o,
  output logic         pme_oe_o,
  output logic         irq_o
);

  ind_cfg_t cfg_q;
  logic     any_hit;
  logic     clr_release;
  logic     release_evt;
  logic     active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_wr_i) cfg_q <= ind_cfg_t'(cfg_wdata_i);
  end

  wake_event_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .det_i         ({frame_det_i, magic_det_i}),
    .wake_wr_i     (wake_wr_i),
    .wake_wdata_i  (wake_wdata_i),
    .any_hit_o     (any_hit),
    .clr_release_o (clr_release),
    .flags_o       (wake_flags_o)
  );

  assign release_evt = pm_wr_i | clr_release;

  wake_active_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) u_active (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_i        (any_hit),
    .release_i    (release_evt),
    .pulse_mode_i (cfg_q.pulse_mode),
    .active_o     (active)
  );

  wake_pad_drive u_pad (
    .active_i   (active),
    .cfg_i      (cfg_q),
    .sys_irq_i  (sys_irq_i),
    .pme_data_o (pme_data_o),
    .pme_oe_o   (pme_oe_o),
    .irq_o      (irq_o)
  );

  AST_OD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.open_drain && pme_oe_o) |-> (pme_data_o == cfg_q.active_high));  // R9
  AST_PP_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.open_drain |-> pme_oe_o);  // R9
  AST_HIT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> active);  // R4
  AST_IRQ_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_irq_i |-> (irq_o == cfg_q.irq_high));  // R10

endmodule

// File: tb/wake_indicator_test.sv
module wake_indicator_test;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic magic_det_i = 0, frame_det_i = 0, wake_wr_i = 0, pm_wr_i = 0;
  logic cfg_wr_i = 0, sys_irq_i = 0;
  logic [3:0] wake_wdata_i = '0;
  logic [4:0] cfg_wdata_i = '0;
  logic [1:0] wake_flags_o;
  logic pme_data_o, pme_oe_o, irq_o;

  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit done = 0;

  // reference model state
  int m_en_m = 0, m_en_f = 0, m_fm = 0, m_ff = 0, m_latch = 0, m_cnt = 0;
  int m_pulse = 0, m_hi = 0, m_od = 0, m_route = 0, m_irqhi = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_indicator #(.PULSE_CYCLES(PULSE)) uut (.*);

  always @(posedge clk) begin
    int mh, fh, nfm, nff, clr_any, relz;
    if (!rst_n) begin
      m_en_m = 0; m_en_f = 0; m_fm = 0; m_ff = 0; m_latch = 0; m_cnt = 0;
      m_pulse = 0; m_hi = 0; m_od = 0; m_route = 0; m_irqhi = 0;
    end else begin
      mh = magic_det_i && m_en_m;
      fh = frame_det_i && m_en_f;
      nfm = mh ? 1 : ((wake_wr_i && wake_wdata_i[2]) ? 0 : m_fm);
      nff = fh ? 1 : ((wake_wr_i && wake_wdata_i[3]) ? 0 : m_ff);
      clr_any = wake_wr_i && (wake_wdata_i[2] || wake_wdata_i[3]);
      relz = pm_wr_i || (clr_any && nfm == 0 && nff == 0);
      if (mh || fh) begin m_latch = 1; m_cnt = PULSE; end
      else if (relz) begin m_latch = 0; m_cnt = 0; end
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_fm = nfm; m_ff = nff;
      if (wake_wr_i) begin m_en_m = wake_wdata_i[0]; m_en_f = wake_wdata_i[1]; end
      if (cfg_wr_i) begin
        m_pulse = cfg_wdata_i[0]; m_hi = cfg_wdata_i[1]; m_od = cfg_wdata_i[2];
        m_route = cfg_wdata_i[3]; m_irqhi = cfg_wdata_i[4];
      end
    end
  end

  always @(negedge clk) begin
    int act, e_oe, e_data, e_irq, irqa;
    act = m_pulse ? (m_cnt > 0) : m_latch;
    e_oe = m_od ? act : 1;
    e_data = m_od ? m_hi : (m_hi ? act : !act);
    irqa = sys_irq_i || (m_route && act);
    e_irq = m_irqhi ? irqa : !irqa;
    if (!done) begin
      checks++;
      if (pme_data_o !== e_data[0] || pme_oe_o !== e_oe[0] || irq_o !== e_irq[0] ||
          wake_flags_o !== {m_ff[0], m_fm[0]}) begin
        failures++;
        $display("FAIL %s t=%0t actual data=%b oe=%b irq=%b flags=%b expected data=%0d oe=%0d irq=%0d flags=%0d%0d",
                 tag, $time, pme_data_o, pme_oe_o, irq_o, wake_flags_o, e_data, e_oe, e_irq, m_ff, m_fm);
      end
    end
  end

  task automatic drive(input logic m, input logic f, input logic ww, input logic [3:0] wd,
                       input logic pw, input logic cw, input logic [4:0] cd);
    @(negedge clk); #1;
    magic_det_i = m; frame_det_i = f; wake_wr_i = ww; wake_wdata_i = wd;
    pm_wr_i = pw; cfg_wr_i = cw; cfg_wdata_i = cd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 4'h0, 0, 0, 5'h0);
  endtask

  task automatic explicit(input string t, input logic ok, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", t, what);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt_act;
    tag = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #2;
    explicit("R1", pme_data_o == 1 && pme_oe_o == 1 && irq_o == 1 && wake_flags_o == 0,
             $sformatf("actual %b%b%b %b expected 111 00", pme_data_o, pme_oe_o, irq_o, wake_flags_o));

    tag = "R2"; // detections with enables off
    drive(1, 0, 0, 0, 0, 0, 0); drive(0, 1, 0, 0, 0, 0, 0); idle(3);
    tag = "R11"; // enable write in same cycle as detection: old enable used
    drive(1, 1, 1, 4'b0001, 0, 0, 0); idle(3);
    tag = "R2"; // magic enabled only: frame ignored
    drive(0, 1, 0, 0, 0, 0, 0); idle(3);
    tag = "R3";
    drive(1, 0, 0, 0, 0, 0, 0); idle(4);
    drive(0, 0, 1, 4'b0011, 0, 0, 0); idle(1);
    drive(0, 1, 0, 0, 0, 0, 0); idle(3);
    tag = "R4"; // clear only magic: frame still set, stays active
    drive(0, 0, 1, 4'b0111, 0, 0, 0); idle(4);
    tag = "R5";
    drive(0, 0, 1, 4'b1011, 0, 0, 0); idle(3);
    tag = "R3"; // detection with same-cycle clear wins
    drive(1, 0, 1, 4'b0111, 0, 0, 0); idle(3);
    tag = "R5"; // pm write releases, flags stay
    drive(0, 0, 0, 0, 1, 0, 0); idle(3);
    drive(0, 1, 0, 0, 1, 0, 0); idle(3); // hit beats pm write
    drive(0, 0, 1, 4'b1111, 0, 0, 0); idle(2);

    tag = "R6";
    drive(0, 0, 0, 0, 0, 1, 5'b00001); idle(2);
    drive(1, 0, 0, 0, 0, 0, 0);
    cnt_act = 0;
    for (int i = 0; i < PULSE + 8; i++) begin
      idle(1);
      #1 if (pme_data_o == 0) cnt_act++;
    end
    explicit("R6", cnt_act == PULSE, $sformatf("actual active=%0d expected %0d", cnt_act, PULSE));
    explicit("R6", wake_flags_o == 2'b01, $sformatf("actual flags=%b expected 01", wake_flags_o));
    tag = "R7";
    drive(0, 1, 0, 0, 0, 0, 0); idle(5);
    drive(1, 0, 0, 0, 0, 0, 0); idle(PULSE + 4);
    tag = "R5";
    drive(1, 0, 0, 0, 0, 0, 0); idle(3);
    drive(0, 0, 0, 0, 1, 0, 0); idle(3);

    tag = "R8";
    drive(0, 0, 0, 0, 0, 1, 5'b00010); idle(2);
    drive(1, 0, 0, 0, 0, 0, 0); idle(3);
    drive(0, 0, 0, 0, 1, 0, 0); idle(2);
    tag = "R9";
    drive(0, 0, 0, 0, 0, 1, 5'b00110); idle(2);
    drive(0, 1, 0, 0, 0, 0, 0); idle(3);
    drive(0, 0, 0, 0, 1, 0, 0); idle(2);
    drive(0, 0, 0, 0, 0, 1, 5'b00100); idle(2);
    drive(1, 0, 0, 0, 0, 0, 0); idle(3);
    drive(0, 0, 0, 0, 1, 0, 0); idle(2);
    tag = "R10";
    drive(0, 0, 0, 0, 0, 1, 5'b11000); idle(2);
    drive(1, 0, 0, 0, 0, 0, 0); idle(3);
    drive(0, 0, 0, 0, 1, 0, 0); idle(2);
    #1 sys_irq_i = 1; idle(3);
    drive(0, 0, 0, 0, 0, 1, 5'b00000); idle(2);
    #1 sys_irq_i = 0; idle(2);
    tag = "R11"; // config change same cycle as detection: pulse applies after
    drive(1, 0, 0, 0, 0, 1, 5'b00001); idle(PULSE + 4);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule